// File: doc/BRIEF.md
# Line Interface System-Side Mode Adapter

This block is the per-channel adapter between a telecom line interface and the system side of a chip. On the transmit side it accepts either dual-rail data (separate positive and negative pulse rails) or single-rail data. It changes between the two forms on its own. In single-rail operation it converts the data to alternate-mark-inversion rail pulses, and in one configuration it can force bipolar violations. Transmit inputs are taken only on falling edges of the transmit clock. The block detects those edges by sampling the transmit clock level with its core clock.

On the receive side it places rail data on three system pins. The rail data comes either from the recovery path or straight from the slicer. In the clock-recovery modes one edge-select pin decides which edge of the outgoing receive clock marks valid data. In raw-slice mode the same pin sets the data polarity instead, and the receive clock is built as the XOR of the two raw rails. Every mode and code choice arrives as a plain input pin.

Top module: `lif_sys_adapter`

## Requirements
- R1: After reset, mode_o reads 0 (dual rail with clock recovery), both transmit rail outputs are low, all receive outputs are low, and the first single-rail mark is sent on the positive rail.
- R2: In a dual-rail mode (mode_o 0 or 3), each transmit-clock falling edge copies tx_dp_i to tx_p_o and tx_dn_i to tx_n_o.
- R3: With both configuration bits clear, 16 consecutive falling-edge samples of tx_dn_i high leave mode_o at 0. The 17th sample sets mode_o to 1 (automatic single rail).
- R4: A low sample of tx_dn_i clears the run count. In mode 1, a low sample returns mode_o to 0.
- R5: When cfg_cr_i and cfg_sr_i are both high, mode_o reads 2 (configured single rail) and tx_dn_i acts as the violation-insert input. Otherwise cfg_raw_i high gives mode_o 3 (raw slice), unless automatic single rail is active.
- R6: In single-rail modes a data one becomes a mark, and mark polarity alternates between positive ({tx_p_o,tx_n_o}=10) and negative (01). A data zero gives 00.
- R7: In mode 2 with AMI coding (cfg_hdb3_i low), an insert sample sends a mark with the polarity of the previous mark, replaces that bit, and does not change which polarity the next mark takes.
- R8: With cfg_hdb3_i high the insert input has no effect on the rail outputs.
- R9: A rising edge of tx_clk_i, or a steady level, leaves the transmit outputs unchanged.
- R10: In modes 0 and 3-free clock-recovery operation (modes 0, 1, 2), rclk_o is rec_clk_i with edge_sel_i low and its inverse with edge_sel_i high. Data outputs stay active high, and in mode 0 rd_p_o and rd_n_o follow rec_p_i and rec_n_i.
- R11: In single-rail modes rd_p_o carries dec_data_i and rd_n_o carries the decoder violation flag dec_cv_i.
- R12: In mode 3, rd_p_o and rd_n_o are raw_p_i and raw_n_i when edge_sel_i is high and their inverses when it is low. rclk_o is raw_p_i XOR raw_n_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_clk_i | input | 1 | Transmit clock level; inputs are taken on its falling edge |
| tx_dp_i | input | 1 | Positive rail, or single-rail data |
| tx_dn_i | input | 1 | Negative rail, or violation insert in mode 2 |
| cfg_cr_i | input | 1 | Clock-recovery select bit |
| cfg_sr_i | input | 1 | Single-rail select bit |
| cfg_raw_i | input | 1 | Raw-slice receive (no clock recovery) |
| cfg_hdb3_i | input | 1 | 1 = HDB3 coding, 0 = AMI |
| edge_sel_i | input | 1 | Clock edge select, or raw polarity |
| rec_p_i | input | 1 | Recovered positive rail |
| rec_n_i | input | 1 | Recovered negative rail |
| rec_clk_i | input | 1 | Recovered clock level |
| raw_p_i | input | 1 | Raw sliced positive rail, active high |
| raw_n_i | input | 1 | Raw sliced negative rail, active high |
| dec_data_i | input | 1 | Decoder data |
| dec_cv_i | input | 1 | Decoder code-violation flag |
| tx_p_o | output | 1 | Transmit positive rail pulse |
| tx_n_o | output | 1 | Transmit negative rail pulse |
| rd_p_o | output | 1 | Receive positive rail or single-rail data |
| rd_n_o | output | 1 | Receive negative rail or violation flag |
| rclk_o | output | 1 | Receive clock out |
| mode_o | output | 2 | 0 dual, 1 auto single, 2 configured single, 3 raw |

## Verification
Transmit outputs and the mode change at the first core-clock edge that sees tx_clk_i low after it was high. The bench holds each transmit-clock phase for two core cycles and reads results two cycles after the falling level. Mode entry therefore shows up right after the 17th falling edge, and its rail effect appears from the next strobe on. Receive outputs are one register deep, so the bench applies receive inputs on a falling core edge and reads them on the next one.

// File: rtl/lif_pkg.sv
`timescale 1ns/1ps
package lif_pkg;

  typedef enum logic [1:0] {
    SM_DUAL    = 2'd0,
    SM_SR_AUTO = 2'd1,
    SM_SR_CFG  = 2'd2,
    SM_RAW     = 2'd3
  } sys_mode_t;

  // Mode priority: configured single > automatic single > raw > dual
  function automatic sys_mode_t pick_mode(input logic cfg_single,
                                          input logic auto_single,
                                          input logic raw_sel);
    if (cfg_single)       return SM_SR_CFG;
    else if (auto_single) return SM_SR_AUTO;
    else if (raw_sel)     return SM_RAW;
    else                  return SM_DUAL;
  endfunction

  function automatic logic is_single(input sys_mode_t m);
    return (m == SM_SR_AUTO) || (m == SM_SR_CFG);
  endfunction

  // Rail pair {p,n} for a mark of the given polarity (1 = positive)
  function automatic logic [1:0] mark_rails(input logic positive);
    return positive ? 2'b10 : 2'b01;
  endfunction

  // Raw rail after polarity choice (hi_active = 1 keeps it active high)
  function automatic logic apply_pol(input logic v, input logic hi_active);
    return hi_active ? v : ~v;
  endfunction

endpackage

// File: rtl/lif_run_detect.sv
`timescale 1ns/1ps
module lif_run_detect #(
  parameter int RUN_THRESH = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_i,
  input  logic line_hi_i,
  output logic auto_o
);
  localparam int LIMIT = RUN_THRESH + 1;
  localparam int CW    = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIMIT_C = CW'(LIMIT);

  logic [CW-1:0] run_q;
  logic          auto_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= '0;
      auto_q <= 1'b0;
    end else if (strobe_i) begin
      if (line_hi_i) begin
        if (run_q != LIMIT_C) run_q <= run_q + 1'b1;
        if (run_q >= LIMIT_C - 1'b1) auto_q <= 1'b1;
      end else begin
        run_q  <= '0;
        auto_q <= 1'b0;
      end
    end
  end

  assign auto_o = auto_q;
endmodule

// File: rtl/lif_tx_encode.sv
`timescale 1ns/1ps
module lif_tx_encode
  import lif_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      strobe_i,
  input  sys_mode_t mode_i,
  input  logic      hdb3_i,
  input  logic      dp_i,
  input  logic      dn_i,
  output logic      viol_o,
  output logic      tx_p_o,
  output logic      tx_n_o
);
  logic pos_next_q;
  logic single_w;
  logic viol_w;

  assign single_w = is_single(mode_i);
  assign viol_w   = (mode_i == SM_SR_CFG) && !hdb3_i && dn_i;
  assign viol_o   = strobe_i && viol_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_p_o     <= 1'b0;
      tx_n_o     <= 1'b0;
      pos_next_q <= 1'b1;
    end else if (strobe_i) begin
      if (!single_w) begin
        tx_p_o <= dp_i;
        tx_n_o <= dn_i;
      end else if (viol_w) begin
        {tx_p_o, tx_n_o} <= mark_rails(~pos_next_q);
      end else if (dp_i) begin
        {tx_p_o, tx_n_o} <= mark_rails(pos_next_q);
        pos_next_q       <= ~pos_next_q;
      end else begin
        tx_p_o <= 1'b0;
        tx_n_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lif_rx_format.sv
`timescale 1ns/1ps
module lif_rx_format
  import lif_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  sys_mode_t mode_i,
  input  logic      edge_sel_i,
  input  logic      rec_p_i,
  input  logic      rec_n_i,
  input  logic      rec_clk_i,
  input  logic      raw_p_i,
  input  logic      raw_n_i,
  input  logic      dec_data_i,
  input  logic      dec_cv_i,
  output logic      rd_p_o,
  output logic      rd_n_o,
  output logic      rclk_o
);
  logic p_d, n_d, c_d;

  always_comb begin
    c_d = rec_clk_i ^ edge_sel_i;
    case (mode_i)
      SM_RAW: begin
        p_d = apply_pol(raw_p_i, edge_sel_i);
        n_d = apply_pol(raw_n_i, edge_sel_i);
        c_d = raw_p_i ^ raw_n_i;
      end
      SM_SR_AUTO, SM_SR_CFG: begin
        p_d = dec_data_i;
        n_d = dec_cv_i;
      end
      default: begin
        p_d = rec_p_i;
        n_d = rec_n_i;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_p_o <= 1'b0;
      rd_n_o <= 1'b0;
      rclk_o <= 1'b0;
    end else begin
      rd_p_o <= p_d;
      rd_n_o <= n_d;
      rclk_o <= c_d;
    end
  end
endmodule

// File: rtl/lif_sys_adapter.sv
`timescale 1ns/1ps
module lif_sys_adapter
  import lif_pkg::*;
#(
  parameter int RUN_THRESH = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tx_clk_i,
  input  logic       tx_dp_i,
  input  logic       tx_dn_i,
  input  logic       cfg_cr_i,
  input  logic       cfg_sr_i,
  input  logic       cfg_raw_i,
  input  logic       cfg_hdb3_i,
  input  logic       edge_sel_i,
  input  logic       rec_p_i,
  input  logic       rec_n_i,
  input  logic       rec_clk_i,
  input  logic       raw_p_i,
  input  logic       raw_n_i,
  input  logic       dec_data_i,
  input  logic       dec_cv_i,
  output logic       tx_p_o,
  output logic       tx_n_o,
  output logic       rd_p_o,
  output logic       rd_n_o,
  output logic       rclk_o,
  output logic [1:0] mode_o
);
  logic      tclk_q;
  logic      strobe_w;
  logic      auto_w;
  logic      viol_ev_w;
  sys_mode_t mode_w;

  always_ff @(posedge clk) begin
    if (rst) tclk_q <= 1'b0;
    else     tclk_q <= tx_clk_i;
  end

  assign strobe_w = tclk_q && !tx_clk_i;
  assign mode_w   = pick_mode(cfg_cr_i && cfg_sr_i, auto_w, cfg_raw_i);
  assign mode_o   = mode_w;

  lif_run_detect #(.RUN_THRESH(RUN_THRESH)) u_run (
    .clk(clk), .rst(rst), .strobe_i(strobe_w),
    .line_hi_i(tx_dn_i), .auto_o(auto_w)
  );

  lif_tx_encode u_tx (
    .clk(clk), .rst(rst), .strobe_i(strobe_w), .mode_i(mode_w),
    .hdb3_i(cfg_hdb3_i), .dp_i(tx_dp_i), .dn_i(tx_dn_i),
    .viol_o(viol_ev_w), .tx_p_o(tx_p_o), .tx_n_o(tx_n_o)
  );

  lif_rx_format u_rx (
    .clk(clk), .rst(rst), .mode_i(mode_w), .edge_sel_i(edge_sel_i),
    .rec_p_i(rec_p_i), .rec_n_i(rec_n_i), .rec_clk_i(rec_clk_i),
    .raw_p_i(raw_p_i), .raw_n_i(raw_n_i),
    .dec_data_i(dec_data_i), .dec_cv_i(dec_cv_i),
    .rd_p_o(rd_p_o), .rd_n_o(rd_n_o), .rclk_o(rclk_o)
  );
endmodule

// File: rtl/lif_sys_adapter_chk.sv
`timescale 1ns/1ps
module lif_sys_adapter_chk (
  input logic       clk,
  input logic       rst,
  input logic       strobe_w,
  input logic       auto_w,
  input logic       viol_ev_w,
  input logic       tx_dn_i,
  input logic       cfg_hdb3_i,
  input logic       edge_sel_i,
  input logic       rec_clk_i,
  input logic       raw_p_i,
  input logic       raw_n_i,
  input logic       tx_p_o,
  input logic       tx_n_o,
  input logic       rclk_o,
  input logic [1:0] mode_o
);
  p_auto_entry_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(auto_w) |-> $past(strobe_w) && $past(tx_dn_i));

  p_auto_exit_r4: assert property (@(posedge clk) disable iff (rst)
    (strobe_w && !tx_dn_i) |=> !auto_w);

  p_single_mark_r6: assert property (@(posedge clk) disable iff (rst)
    (strobe_w && (mode_o == 2'd1 || mode_o == 2'd2)) |=> !(tx_p_o && tx_n_o));

  p_hdb3_no_insert_r8: assert property (@(posedge clk) disable iff (rst)
    viol_ev_w |-> !cfg_hdb3_i);

  p_hold_between_r9: assert property (@(posedge clk) disable iff (rst)
    !strobe_w |=> $stable({tx_p_o, tx_n_o}));

  p_edge_clk_r10: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'd0) |=> rclk_o == ($past(rec_clk_i) ^ $past(edge_sel_i)));

  p_raw_xor_r12: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'd3) |=> rclk_o == ($past(raw_p_i) ^ $past(raw_n_i)));
endmodule

bind lif_sys_adapter lif_sys_adapter_chk u_chk (
  .clk(clk), .rst(rst), .strobe_w(strobe_w), .auto_w(auto_w),
  .viol_ev_w(viol_ev_w), .tx_dn_i(tx_dn_i), .cfg_hdb3_i(cfg_hdb3_i),
  .edge_sel_i(edge_sel_i), .rec_clk_i(rec_clk_i), .raw_p_i(raw_p_i),
  .raw_n_i(raw_n_i), .tx_p_o(tx_p_o), .tx_n_o(tx_n_o), .rclk_o(rclk_o),
  .mode_o(mode_o)
);

// File: tb/lif_sys_adapter_bench.sv
`timescale 1ns/1ps
module lif_sys_adapter_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_clk = 0, tdp = 0, tdn = 0;
  logic cr = 0, sr = 0, rawsel = 0, hdb3 = 0, esel = 0;
  logic rp = 0, rn = 0, rc = 0, wp = 0, wn = 0, dd = 0, dcv = 0;
  logic tp, tn, qp, qn, qc;
  logic [1:0] mode;
  int checks = 0;
  int fails  = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lif_sys_adapter u_lif_sys_adapter (
    .clk(clk), .rst(rst), .tx_clk_i(tx_clk), .tx_dp_i(tdp), .tx_dn_i(tdn),
    .cfg_cr_i(cr), .cfg_sr_i(sr), .cfg_raw_i(rawsel), .cfg_hdb3_i(hdb3),
    .edge_sel_i(esel), .rec_p_i(rp), .rec_n_i(rn), .rec_clk_i(rc),
    .raw_p_i(wp), .raw_n_i(wn), .dec_data_i(dd), .dec_cv_i(dcv),
    .tx_p_o(tp), .tx_n_o(tn), .rd_p_o(qp), .rd_n_o(qn), .rclk_o(qc),
    .mode_o(mode)
  );

  // {data, insert, hdb3, exp_p, exp_n}, run in mode 2 right after reset
  localparam logic [4:0] VEC [10] = '{
    5'b100_10, 5'b000_00, 5'b100_01, 5'b100_10, 5'b010_10,
    5'b100_01, 5'b011_00, 5'b101_10, 5'b110_10, 5'b100_01
  };

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; tx_clk = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
  endtask

  task automatic tx_bit(input logic p, input logic n);
    @(negedge clk); tx_clk = 1; tdp = p; tdn = n;
    @(negedge clk); tx_clk = 0;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic rx_step();
    @(negedge clk); @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R1 reset mode", {2'b0, mode}, 4'd0);
    chk("R1 reset tx", {2'b0, tp, tn}, 4'd0);
    chk("R1 reset rx", {1'b0, qp, qn, qc}, 4'd0);

    // R2 dual pass-through
    tx_bit(1, 0); chk("R2 dual 10", {2'b0, tp, tn}, 4'b0010);
    tx_bit(0, 1); chk("R2 dual 01", {2'b0, tp, tn}, 4'b0001);

    // R9 rising edge has no effect
    @(negedge clk); tx_clk = 1; tdp = 1; tdn = 0;
    @(negedge clk); @(negedge clk);
    chk("R9 rising ignored", {2'b0, tp, tn}, 4'b0001);
    tx_clk = 0; @(negedge clk); @(negedge clk);
    chk("R9 falling taken", {2'b0, tp, tn}, 4'b0010);

    // R3 thresholds
    for (int i = 0; i < 16; i++) tx_bit(0, 1);
    chk("R3 16 highs stay dual", {2'b0, mode}, 4'd0);
    tx_bit(0, 1);
    chk("R3 17th high enters auto", {2'b0, mode}, 4'd1);
    tx_bit(1, 1); chk("R6 auto first mark pos", {2'b0, tp, tn}, 4'b0010);
    tx_bit(1, 1); chk("R6 auto second mark neg", {2'b0, tp, tn}, 4'b0001);
    tx_bit(0, 0);
    chk("R4 low exits auto", {2'b0, mode}, 4'd0);
    for (int i = 0; i < 10; i++) tx_bit(0, 1);
    tx_bit(0, 0);
    for (int i = 0; i < 16; i++) tx_bit(0, 1);
    chk("R4 low restarts run", {2'b0, mode}, 4'd0);
    tx_bit(0, 1);
    chk("R3 re-entry after 17", {2'b0, mode}, 4'd1);
    tx_bit(0, 0);

    // Vector table in configured single-rail mode
    do_reset();
    cr = 1; sr = 1; @(negedge clk);
    chk("R5 configured single", {2'b0, mode}, 4'd2);
    for (int k = 0; k < 10; k++) begin
      hdb3 = VEC[k][2];
      tx_bit(VEC[k][4], VEC[k][3]);
      chk(VEC[k][3] ? (VEC[k][2] ? "R8 insert under HDB3" : "R7 insert under AMI")
                    : "R6 AMI mark",
          {2'b0, tp, tn}, {2'b0, VEC[k][1:0]});
    end
    hdb3 = 0;

    // R11 single-rail receive
    dd = 1; dcv = 0; rc = 1; esel = 0; rx_step();
    chk("R11 data on rd_p", {1'b0, qp, qn, qc}, 4'b0101);
    dd = 0; dcv = 1; rx_step();
    chk("R11 cv on rd_n", {1'b0, qp, qn, qc}, 4'b0011);

    // R10 dual receive
    cr = 0; sr = 0; rp = 1; rn = 0; rc = 1; esel = 0; rx_step();
    chk("R10 rising edge mode", {1'b0, qp, qn, qc}, 4'b0101);
    esel = 1; rx_step();
    chk("R10 falling edge mode", {1'b0, qp, qn, qc}, 4'b0100);

    // R12 raw slice
    rawsel = 1; esel = 1; wp = 1; wn = 0; rx_step();
    chk("R12 raw active high", {mode, qp, qn}, 4'b1110);
    chk("R12 xor clk 10", {3'b0, qc}, 4'd1);
    wp = 0; wn = 0; rx_step();
    chk("R12 xor clk 00", {1'b0, qp, qn, qc}, 4'b0000);
    esel = 0; wp = 0; wn = 1; rx_step();
    chk("R12 raw active low", {1'b0, qp, qn, qc}, 4'b0101);
    wp = 1; wn = 1; rx_step();
    chk("R12 xor clk 11", {1'b0, qp, qn, qc}, 4'b0000);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule